// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block decides whether an embedded flash array may be placed in program mode or erase mode. Software writes a small set of registers: a control register with a write-enable lock, program and erase request bits, and program-verify and erase-verify request bits. Two block-mask registers select, per flash block, which blocks may be erased. An emulation-select input, driven from outside the block, locks out both program and erase for every block while it is high.

The controller turns these settings into registered mode outputs to the array and a per-block erase-enable vector. While a program or erase operation is running it watches the CPU read bus. A read that lands inside the flash address window is treated as a runaway. The operation is aborted in that same cycle and a sticky error flag is raised. While the flag is set, program and erase cannot be entered again, but the verify modes stay available. Only reset clears the flag. The cell model, pulse timing and the programming algorithm sit outside this block.

Top module: `flash_guard`

## Requirements
- R1: While the write-enable bit (control register bit 0) is 0, neither program mode nor erase mode is entered, whatever the request bits hold.
- R2: While the emulation-select input is 1, neither program mode nor erase mode is entered. Verify modes are not affected by this input.
- R3: Program request (control bit 1) and erase request (control bit 2) are mutually exclusive. When both are 1, neither mode is entered.
- R4: A write to the control register takes effect at the clock edge that captures it. The mode outputs then follow the stored control bits at the next clock edge. Mode outputs rise and fall with this one-edge lag.
- R5: Block i may be erased only if bit i of block mask A (address 1) and bit i of block mask B (address 2) are both 1. The erase-enable output is the AND of the two masks, gated by erase mode. When both masks are zero, no block receives an erase enable.
- R6: A read on the monitored bus with an address in [FLASH_BASE, FLASH_BASE+FLASH_SIZE), made while program or erase mode is active, sets the error flag (control bit 7) at the next edge. A read outside that window does not set it. A read made while no such mode is active does not set it either.
- R7: An offending read drops the program and erase mode outputs and all erase enables combinationally, in the cycle of the read. The control and mask register contents are left unchanged by the abort.
- R8: The error flag is sticky and is cleared only by reset. Writes to control bit 7 are ignored.
- R9: While the error flag is set, program and erase requests are stored when written but do not enter their modes.
- R10: With the write-enable bit at 1, program-verify (control bit 3) or erase-verify (control bit 4) enters the matching verify mode with the R4 timing, also while the error flag is set. Both verify bits at once enter neither mode. A verify mode is also not entered while a program or erase mode is being entered.
- R11: Registers read back through the combinational read port at their addresses. Address 0 returns {error, 2'b00, erase-verify, program-verify, erase req, program req, write-enable}. Address 3 reads 0. All registers and outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| emu_sel | input | 1 | Emulation select; locks out program and erase |
| bus_rd_valid | input | 1 | Monitored bus read strobe (data, fetch or vector read) |
| bus_rd_addr | input | AW | Monitored bus read address |
| prog_mode_o | output | 1 | Program mode to the array |
| erase_mode_o | output | 1 | Erase mode to the array |
| pverify_o | output | 1 | Program-verify mode |
| everify_o | output | 1 | Erase-verify mode |
| blk_erase_en_o | output | NBLK | Per-block erase enable |
| err_o | output | 1 | Sticky error flag |

## Verification
Two things can happen in the same cycle. An illegal flash read can abort an active operation while software writes the control or mask registers. The write must be stored, the mode outputs must fall at once, and the flag must rise at the next edge. Directed steps place a control write and an in-window read on one cycle, and the constrained-random phase mixes writes and bus reads freely. A cycle-accurate bench model compares every output and the read-back value on each cycle.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_MASKA = 2'd1,
    A_MASKB = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_e;

  localparam int CB_WEN = 0;
  localparam int CB_PRQ = 1;
  localparam int CB_ERQ = 2;
  localparam int CB_PVR = 3;
  localparam int CB_EVR = 4;
  localparam int CB_ERR = 7;

  typedef struct packed {
    logic ev_req;
    logic pv_req;
    logic er_req;
    logic pr_req;
    logic wen;
  } ctrl_t;

endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flash_guard_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            err_i,
  output ctrl_t           ctrl_o,
  output logic [NBLK-1:0] mask_a_o,
  output logic [NBLK-1:0] mask_b_o,
  output logic [DW-1:0]   rdata_o
);

  ctrl_t           ctrl_q, ctrl_d;
  logic [NBLK-1:0] ma_q, ma_d, mb_q, mb_d;
  logic            ctrl_ld, ma_ld, mb_ld;

  assign ctrl_ld = wr_i && (addr_i == A_CTRL);
  assign ma_ld   = wr_i && (addr_i == A_MASKA);
  assign mb_ld   = wr_i && (addr_i == A_MASKB);

  // next-state: error bit of the write data is dropped here
  always_comb begin
    ctrl_d.wen    = wdata_i[CB_WEN];
    ctrl_d.pr_req = wdata_i[CB_PRQ];
    ctrl_d.er_req = wdata_i[CB_ERQ];
    ctrl_d.pv_req = wdata_i[CB_PVR];
    ctrl_d.ev_req = wdata_i[CB_EVR];
    ma_d          = wdata_i[NBLK-1:0];
    mb_d          = wdata_i[NBLK-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ma_q   <= '0;
      mb_q   <= '0;
    end else begin
      if (ctrl_ld) ctrl_q <= ctrl_d;
      if (ma_ld)   ma_q   <= ma_d;
      if (mb_ld)   mb_q   <= mb_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      A_CTRL: begin
        rdata_o[CB_WEN] = ctrl_q.wen;
        rdata_o[CB_PRQ] = ctrl_q.pr_req;
        rdata_o[CB_ERQ] = ctrl_q.er_req;
        rdata_o[CB_PVR] = ctrl_q.pv_req;
        rdata_o[CB_EVR] = ctrl_q.ev_req;
        rdata_o[CB_ERR] = err_i;
      end
      A_MASKA: rdata_o = DW'(ma_q);
      A_MASKB: rdata_o = DW'(mb_q);
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign mask_a_o = ma_q;
  assign mask_b_o = mb_q;

  // R11 / R7: register contents change only through a write to their address
  p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_ld |=> $stable(ctrl_q));
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ma_ld && !mb_ld) |=> ($stable(ma_q) && $stable(mb_q)));

endmodule

// File: rtl/flash_guard_err.sv
module flash_guard_err #(
  parameter int AW         = 16,
  parameter int FLASH_BASE = 'h1000,
  parameter int FLASH_SIZE = 'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          op_active_i,
  output logic          hit_o,
  output logic          err_o
);

  localparam logic [AW:0] WIN_LO = FLASH_BASE[AW:0];
  localparam logic [AW:0] WIN_HI = WIN_LO + FLASH_SIZE[AW:0];

  logic in_win;
  logic err_q, err_d;

  assign in_win = ({1'b0, rd_addr_i} >= WIN_LO) && ({1'b0, rd_addr_i} < WIN_HI);
  assign hit_o  = rd_valid_i && in_win && op_active_i && !err_q;

  always_comb begin
    err_d = err_q | hit_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;

  // R8: once set, the flag stays until reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R6: the flag only rises after a read during an active operation
  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(rd_valid_i && op_active_i));

endmodule

// File: rtl/flash_guard_mode.sv
module flash_guard_mode
  import flash_guard_pkg::*;
#(
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctrl_t           ctrl_i,
  input  logic            emu_i,
  input  logic            err_i,
  input  logic            hit_i,
  input  logic [NBLK-1:0] mask_a_i,
  input  logic [NBLK-1:0] mask_b_i,
  output logic            op_active_o,
  output logic            prog_o,
  output logic            erase_o,
  output logic            pv_o,
  output logic            ev_o,
  output logic [NBLK-1:0] blk_en_o
);

  logic prog_q, erase_q, pv_q, ev_q;
  logic prog_d, erase_d, pv_d, ev_d;
  logic pe_allowed;

  // all three software locks plus the error lock
  assign pe_allowed = ctrl_i.wen && !emu_i && !err_i && !hit_i;

  always_comb begin
    prog_d  = pe_allowed && ctrl_i.pr_req && !ctrl_i.er_req;
    erase_d = pe_allowed && ctrl_i.er_req && !ctrl_i.pr_req;
    pv_d    = ctrl_i.wen && ctrl_i.pv_req && !ctrl_i.ev_req && !prog_d && !erase_d;
    ev_d    = ctrl_i.wen && ctrl_i.ev_req && !ctrl_i.pv_req && !prog_d && !erase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      pv_q    <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      prog_q  <= prog_d;
      erase_q <= erase_d;
      pv_q    <= pv_d;
      ev_q    <= ev_d;
    end
  end

  assign op_active_o = prog_q || erase_q;
  assign prog_o      = prog_q && !hit_i;
  assign erase_o     = erase_q && !hit_i;
  assign pv_o        = pv_q;
  assign ev_o        = ev_q;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blk_en_o[b] = mask_a_i[b] && mask_b_i[b] && erase_o;
  end

  p_wen_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(prog_q) || $rose(erase_q)) |-> $past(ctrl_i.wen));
  p_emu_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(prog_q) || $rose(erase_q)) |-> !$past(emu_i));
  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_q, erase_q, pv_q, ev_q}));
  p_no_op_in_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |-> (!prog_q && !erase_q));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 16,
  parameter int NBLK       = 8,
  parameter int FLASH_BASE = 'h1000,
  parameter int FLASH_SIZE = 'h8000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            emu_sel,
  input  logic            bus_rd_valid,
  input  logic [AW-1:0]   bus_rd_addr,
  output logic            prog_mode_o,
  output logic            erase_mode_o,
  output logic            pverify_o,
  output logic            everify_o,
  output logic [NBLK-1:0] blk_erase_en_o,
  output logic            err_o
);

  ctrl_t           ctrl;
  logic [NBLK-1:0] mask_a, mask_b;
  logic            err, hit, op_active;

  flash_guard_regs #(.DW(DW), .NBLK(NBLK)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .err_i(err), .ctrl_o(ctrl),
    .mask_a_o(mask_a), .mask_b_o(mask_b), .rdata_o(reg_rdata)
  );

  flash_guard_err #(.AW(AW), .FLASH_BASE(FLASH_BASE), .FLASH_SIZE(FLASH_SIZE)) err_i (
    .clk(clk), .rst_n(rst_n), .rd_valid_i(bus_rd_valid), .rd_addr_i(bus_rd_addr),
    .op_active_i(op_active), .hit_o(hit), .err_o(err)
  );

  flash_guard_mode #(.NBLK(NBLK)) mode_i (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .emu_i(emu_sel), .err_i(err),
    .hit_i(hit), .mask_a_i(mask_a), .mask_b_i(mask_b), .op_active_o(op_active),
    .prog_o(prog_mode_o), .erase_o(erase_mode_o), .pv_o(pverify_o),
    .ev_o(everify_o), .blk_en_o(blk_erase_en_o)
  );

  assign err_o = err;

  p_erase_en_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|blk_erase_en_o) |-> erase_mode_o);
  p_abort_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (!prog_mode_o && !erase_mode_o && !(|blk_erase_en_o)));

endmodule

// File: tb/flash_guard_tb.sv
`timescale 1ns/100ps
module flash_guard_tb_top;
  localparam int DW = 8, AW = 16, NBLK = 8;
  localparam int FB = 'h1000, FS = 'h8000;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic emu_sel, bus_rd_valid;
  logic [AW-1:0] bus_rd_addr;
  logic prog_mode_o, erase_mode_o, pverify_o, everify_o, err_o;
  logic [NBLK-1:0] blk_erase_en_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // model state
  bit m_wen, m_pr, m_er, m_pv, m_ev, m_err, m_prog, m_erase, m_pvq, m_evq;
  logic [NBLK-1:0] m_ma, m_mb;

  always #2.5 clk = ~clk;

  flash_guard #(.DW(DW), .AW(AW), .NBLK(NBLK), .FLASH_BASE(FB), .FLASH_SIZE(FS)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .emu_sel(emu_sel),
    .bus_rd_valid(bus_rd_valid), .bus_rd_addr(bus_rd_addr),
    .prog_mode_o(prog_mode_o), .erase_mode_o(erase_mode_o),
    .pverify_o(pverify_o), .everify_o(everify_o),
    .blk_erase_en_o(blk_erase_en_o), .err_o(err_o)
  );

  function automatic bit exp_hit();
    int a = int'(bus_rd_addr);
    return bus_rd_valid && (a >= FB) && (a < FB + FS) && (m_prog || m_erase) && !m_err;
  endfunction

  function automatic logic [DW-1:0] exp_rdata();
    case (reg_addr)
      2'd0: return {m_err, 2'b00, m_ev, m_pv, m_er, m_pr, m_wen};
      2'd1: return m_ma;
      2'd2: return m_mb;
      default: return '0;
    endcase
  endfunction

  function automatic logic [20:0] exp_vec();
    bit h = exp_hit();
    bit er = m_erase && !h;
    return {m_prog && !h, er, m_pvq, m_evq, m_err, (m_ma & m_mb & {NBLK{er}}), exp_rdata()};
  endfunction

  task automatic model_clear();
    {m_wen, m_pr, m_er, m_pv, m_ev, m_err, m_prog, m_erase, m_pvq, m_evq} = '0;
    m_ma = '0; m_mb = '0;
  endtask

  task automatic model_edge();
    bit h = exp_hit();
    bit ok = m_wen && !emu_sel && !m_err && !h;
    bit pd = ok && m_pr && !m_er;
    bit ed = ok && m_er && !m_pr;
    m_pvq = m_wen && m_pv && !m_ev && !pd && !ed;
    m_evq = m_wen && m_ev && !m_pv && !pd && !ed;
    m_prog = pd; m_erase = ed;
    m_err = m_err || h;
    if (reg_wr) begin
      case (reg_addr)
        2'd0: {m_ev, m_pv, m_er, m_pr, m_wen} = reg_wdata[4:0];
        2'd1: m_ma = reg_wdata;
        2'd2: m_mb = reg_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic check(string tag);
    logic [20:0] act, exp;
    act = {prog_mode_o, erase_mode_o, pverify_o, everify_o, err_o, blk_erase_en_o, reg_rdata};
    exp = exp_vec();
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (prog,erase,pv,ev,err,en,rdata)", tag, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check, let the rising edge happen
  task automatic step(bit wr, logic [1:0] a, logic [7:0] d, bit emu, bit rv,
                      logic [AW-1:0] ra, string tag);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; emu_sel = emu;
    bus_rd_valid = rv; bus_rd_addr = ra;
    #1;
    check(tag);
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(int n, logic [1:0] a, string tag);
    for (int i = 0; i < n; i++) step(0, a, 8'h00, 0, 0, 16'h0000, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; emu_sel = 0;
    bus_rd_valid = 0; bus_rd_addr = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    do_reset();
    // R11: reset values on every address
    for (int a = 0; a < 4; a++) idle(1, 2'(a), "R11 reset");

    // R1: requests without the write-enable lock
    step(1, 0, 8'h02, 0, 0, 0, "R1 write");
    idle(3, 0, "R1 prog blocked");
    step(1, 0, 8'h04, 0, 0, 0, "R1 write");
    idle(3, 0, "R1 erase blocked");

    // R4: program entry timing and exit
    step(1, 0, 8'h03, 0, 0, 0, "R4 write");
    idle(3, 0, "R4 entry");
    step(1, 0, 8'h01, 0, 0, 0, "R4 clear");
    idle(2, 0, "R4 exit");

    // R3: both requests
    step(1, 0, 8'h07, 0, 0, 0, "R3 write");
    idle(3, 0, "R3 neither");

    // R2: emulation lock, verify unaffected
    step(1, 0, 8'h03, 1, 0, 0, "R2 write");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, "R2 prog locked");
    step(1, 0, 8'h09, 1, 0, 0, "R2 verify write");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, "R2 verify ok");

    // R5: block masks
    step(1, 1, 8'hF0, 0, 0, 0, "R5 mask a");
    step(1, 2, 8'h3C, 0, 0, 0, "R5 mask b");
    step(1, 0, 8'h05, 0, 0, 0, "R5 erase");
    idle(3, 1, "R5 enable 0x30");
    step(1, 1, 8'h00, 0, 0, 0, "R5 mask a zero");
    step(1, 2, 8'h00, 0, 0, 0, "R5 mask b zero");
    idle(2, 2, "R5 none enabled");
    step(1, 1, 8'hFF, 0, 0, 0, "R5 mask a ff");
    step(1, 2, 8'h81, 0, 0, 0, "R5 mask b 81");

    // R6: reads outside the window do not trip; R6/R7 inside trips
    step(0, 0, 0, 0, 1, 16'h0FFF, "R6 below window");
    step(0, 0, 0, 0, 1, 16'h9000, "R6 above window");
    idle(1, 0, "R6 no error");
    // R7: in-window read coinciding with a control write (same cycle)
    step(1, 0, 8'h0D, 0, 1, 16'h1000, "R7 abort with write");
    idle(1, 0, "R6 flag set");
    idle(1, 1, "R7 mask a kept");
    idle(1, 2, "R7 mask b kept");

    // R8: writes to the flag bit are ignored
    step(1, 0, 8'h80, 0, 0, 0, "R8 write 1");
    step(1, 0, 8'h00, 0, 0, 0, "R8 write 0");
    idle(2, 0, "R8 sticky");

    // R9: no re-entry
    step(1, 0, 8'h03, 0, 0, 0, "R9 prog again");
    idle(3, 0, "R9 blocked");
    step(1, 0, 8'h05, 0, 0, 0, "R9 erase again");
    idle(3, 0, "R9 blocked");

    // R10: verify modes under error
    step(1, 0, 8'h09, 0, 0, 0, "R10 pverify");
    idle(2, 0, "R10 pverify on");
    step(1, 0, 8'h11, 0, 0, 0, "R10 everify");
    idle(2, 0, "R10 everify on");
    step(1, 0, 8'h19, 0, 0, 0, "R10 both");
    idle(2, 0, "R10 neither");

    // R8: reset is the only clear
    do_reset();
    idle(2, 0, "R8 reset clears");

    // R6: read while idle does not trip
    step(0, 0, 0, 0, 1, 16'h2000, "R6 idle read");
    idle(1, 0, "R6 no error");
    // R10: verify blocked while program is entered
    step(1, 0, 8'h0B, 0, 0, 0, "R10 prog wins");
    idle(2, 0, "R10 prog wins");

    // constrained random episodes
    for (int ep = 0; ep < 6; ep++) begin
      do_reset();
      for (int c = 0; c < 400; c++) begin
        bit wr = ($urandom_range(3, 0) == 0);
        logic [1:0] a = 2'($urandom_range(3, 0));
        logic [7:0] d = 8'($urandom_range(255, 0));
        bit emu = ($urandom_range(15, 0) == 0);
        bit rv = ($urandom_range(7, 0) == 0);
        logic [AW-1:0] ra = 16'($urandom_range(65535, 0));
        if (a == 0 && $urandom_range(1, 0) == 1) d[0] = 1'b1;
        step(wr, a, d, emu, rv, ra, "R4 R11 random");
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule